// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date as packed BCD bytes. A single-cycle timebase enable at 32.768 kHz goes into a sub-second prescaler. Each full second of enables yields a one-cycle tick. That tick advances the seconds byte, and carries ripple in the same clock edge into minutes, hours, day of week, date, month and a two-digit year. The date rollover follows the length of each month, and February gets a 29th day in every year whose value is a multiple of four, including year 00. Hours can be kept in 24-hour form or in 12-hour form with a PM flag.

Software sets each field through a register-style write port: a strobe, a 3-bit field select and a data byte. The port has no back-pressure. A write is taken in the cycle its strobe is high, and the new value shows on the field's output after the next rising edge. A cycle that carries a write never advances time. Bit 7 of the seconds byte is a clock-halt control. While it is set, the prescaler and every field hold still. Writing the seconds byte also restarts the prescaler, so the next tick comes one full second after that write.

Top module: `rtcal_core`

## Requirements
- R1: Seconds and minutes hold BCD values 00..59. Seconds advance by one on each tick. A 59 becomes 00 and carries one into minutes, and a minutes 59 becomes 00 and carries one into hours.
- R2: With hour bit 6 clear (24-hour form), hour bits 5:0 count BCD 00..23. The step from 23 gives 00 and carries one day.
- R3: With hour bit 6 set (12-hour form), bit 5 is PM and bits 4:0 count BCD 01..12. The step from 11 gives 12 and toggles PM, and the step from 12 gives 01 with PM unchanged. The day carry occurs only on the step from 11 with PM set.
- R4: Day of week counts 01..07, advances on each day carry, and goes from 07 to 01.
- R5: Date counts from 01 to the month's last day, then goes to 01 and advances the month. Months 04, 06, 09 and 11 end on 30. Month 02 ends on 29 when the BCD year's value is divisible by 4, otherwise on 28. All other months end on 31. Month 12 goes to 01 and advances the year, and year 99 goes to 00.
- R6: Seconds bit 7 is clock-halt. While it is 1, no tick occurs, the prescaler holds and no field changes unless written.
- R7: tick_o is high for one cycle, only in a cycle where tb_en is high, on every DIV_COUNT-th enable accepted while running. All fields advance at the edge that ends that cycle. Nothing changes in a cycle with neither a tick nor a write.
- R8: wr_sel codes are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Code 7 changes nothing. A cycle with wr_en high gives no tick, and the prescaler does not take that cycle's enable.
- R9: A write to the seconds byte clears the prescaler, so the first tick after it comes on the DIV_COUNT-th following enable.
- R10: After reset the fields read seconds 80 (halted, 00), minutes 00, hours 00 (24-hour), day of week 01, date 01, month 01 and year 00, and tick_o is 0.
- R11: Bits with no meaning read as 0 after any write: minutes bit 7, hours bit 7, day-of-week bits 7:3, date bits 7:6 and month bits 7:5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tb_en | input | 1 | One-cycle timebase enable at the 32.768 kHz rate |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | BCD byte to write |
| sec_o | output | 8 | Clock-halt flag in bit 7, BCD seconds below |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | Hour byte: form flag, PM or tens, units |
| dow_o | output | 8 | Day of week 01..07 |
| date_o | output | 8 | BCD date of month |
| month_o | output | 8 | BCD month |
| year_o | output | 8 | BCD two-digit year |
| tick_o | output | 1 | One-cycle pulse when the second advances |

## Verification
The assertions watch on every cycle that seconds and minutes stay valid BCD, that the day of week stays in 01..07, and that the unused bits stay 0. They also check that a tick changes the seconds, that nothing moves without a tick or a write, that a halted clock stays frozen, and what state follows a day-of-week wrap or a year wrap. Month lengths, leap Februaries, the 12-hour PM sequence, the exact tick position after a seconds write and the write-cycle suppression of an enable can only be shown by the bench. It sweeps a full hour of seconds, both hour forms through a whole day, and both the last date and the second-to-last date of every month across several years.

// File: rtl/rtcal_pkg.sv
package rtcal_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int NUM_CTR = 6;

  // counter slots built by the generate loop in the top
  localparam int CI_SEC  = 0;
  localparam int CI_MIN  = 1;
  localparam int CI_DOW  = 2;
  localparam int CI_DATE = 3;
  localparam int CI_MON  = 4;
  localparam int CI_YEAR = 5;

  typedef logic [BYTE_W-1:0] bcd_byte_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6,
    SEL_NONE  = 3'd7
  } field_sel_e;

  localparam bcd_byte_t HOUR_KEEP = 8'h7F;

  function automatic bcd_byte_t bcd_next(bcd_byte_t v);
    bcd_byte_t r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // two-digit BCD year divisible by four: 10t+u = 2t+u (mod 4)
  function automatic logic year_is_leap(bcd_byte_t y);
    logic [4:0] s;
    s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
    return (s[1:0] == 2'b00);
  endfunction

  function automatic bcd_byte_t month_last_date(bcd_byte_t m, bcd_byte_t y);
    bcd_byte_t r;
    case (m)
      8'h02:                      r = year_is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic field_sel_e ctr_sel(int i);
    field_sel_e r;
    case (i)
      CI_SEC:  r = SEL_SEC;
      CI_MIN:  r = SEL_MIN;
      CI_DOW:  r = SEL_DOW;
      CI_DATE: r = SEL_DATE;
      CI_MON:  r = SEL_MONTH;
      default: r = SEL_YEAR;
    endcase
    return r;
  endfunction

  function automatic bcd_byte_t ctr_low(int i);
    bcd_byte_t r;
    case (i)
      CI_DOW, CI_DATE, CI_MON: r = 8'h01;
      default:                 r = 8'h00;
    endcase
    return r;
  endfunction

  function automatic bcd_byte_t ctr_keep(int i);
    bcd_byte_t r;
    case (i)
      CI_SEC:  r = 8'h7F;
      CI_MIN:  r = 8'h7F;
      CI_DOW:  r = 8'h07;
      CI_DATE: r = 8'h3F;
      CI_MON:  r = 8'h1F;
      default: r = 8'hFF;
    endcase
    return r;
  endfunction

  function automatic bcd_byte_t ctr_top(int i);
    bcd_byte_t r;
    case (i)
      CI_SEC, CI_MIN: r = 8'h59;
      CI_DOW:         r = 8'h07;
      CI_MON:         r = 8'h12;
      default:        r = 8'h99;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rtcal_prescaler.sv
module rtcal_prescaler #(
  parameter int DIV_COUNT = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clr_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV_COUNT > 2) ? $clog2(DIV_COUNT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV_COUNT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             at_last;

  assign at_last = (cnt_q == LAST);
  assign tick_o  = en_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (en_i)    cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtcal_bcd_field.sv
module rtcal_bcd_field
  import rtcal_pkg::*;
#(
  parameter bcd_byte_t LOW_VAL   = 8'h00,
  parameter bcd_byte_t KEEP_MASK = 8'hFF
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      load_i,
  input  bcd_byte_t load_val_i,
  input  bcd_byte_t top_i,
  output bcd_byte_t val_o,
  output logic      wrap_o
);
  bcd_byte_t cur_q;
  bcd_byte_t nxt;
  logic      at_top;

  assign at_top = (cur_q == top_i);
  assign wrap_o = step_i && at_top;
  assign val_o  = cur_q;

  always_comb begin
    nxt = cur_q;
    if (load_i)      nxt = load_val_i & KEEP_MASK;
    else if (step_i) nxt = at_top ? LOW_VAL : bcd_next(cur_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= LOW_VAL;
    else        cur_q <= nxt;
  end
endmodule

// File: rtl/rtcal_hour_field.sv
module rtcal_hour_field
  import rtcal_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      step_i,
  input  logic      load_i,
  input  bcd_byte_t load_val_i,
  output bcd_byte_t val_o,
  output logic      day_o
);
  bcd_byte_t  hr_q;
  bcd_byte_t  nxt;
  bcd_byte_t  inc24;
  logic       form12;
  logic       pm;
  logic [4:0] u12;
  logic [4:0] inc12;
  logic [5:0] h24;

  assign form12 = hr_q[6];
  assign pm     = hr_q[5];
  assign u12    = hr_q[4:0];
  assign h24    = hr_q[5:0];
  assign val_o  = hr_q;

  assign inc24 = bcd_next({2'b00, h24});
  assign inc12 = (u12[3:0] == 4'd9) ? 5'h10 : u12 + 5'd1;

  always_comb begin
    day_o = step_i && (form12 ? (pm && (u12 == 5'h11)) : (h24 == 6'h23));
    nxt   = hr_q;
    if (load_i) begin
      nxt = load_val_i & HOUR_KEEP;
    end else if (step_i) begin
      if (form12) begin
        case (u12)
          5'h11:   nxt = {2'b01, ~pm, 5'h12};
          5'h12:   nxt = {2'b01, pm, 5'h01};
          default: nxt = {2'b01, pm, inc12};
        endcase
      end else begin
        nxt = (h24 == 6'h23) ? 8'h00 : {2'b00, inc24[5:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hr_q <= 8'h00;
    else        hr_q <= nxt;
  end
endmodule

// File: rtl/rtcal_core.sv
module rtcal_core
  import rtcal_pkg::*;
#(
  parameter int DIV_COUNT = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tb_en,
  input  logic       wr_en,
  input  logic [2:0] wr_sel,
  input  logic [7:0] wr_data,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       tick_o
);
  logic            halt_q;
  logic            sec_wr;
  logic            run_en;
  logic            tick;
  logic            day_carry;
  logic            hour_step;
  logic [NUM_CTR-1:0] fld_step;
  logic [NUM_CTR-1:0] fld_wrap;
  bcd_byte_t       fld_val [NUM_CTR];
  bcd_byte_t       fld_top [NUM_CTR];
  bcd_byte_t       hour_val;

  assign sec_wr = wr_en && (wr_sel == SEL_SEC);
  assign run_en = tb_en && !halt_q && !wr_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      halt_q <= 1'b1;
    else if (sec_wr) halt_q <= wr_data[7];
  end

  rtcal_prescaler #(.DIV_COUNT(DIV_COUNT)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (run_en),
    .clr_i  (sec_wr),
    .tick_o (tick)
  );

  // carry chain, all in one cycle
  assign fld_step[CI_SEC]  = tick;
  assign fld_step[CI_MIN]  = fld_wrap[CI_SEC];
  assign hour_step         = fld_wrap[CI_MIN];
  assign fld_step[CI_DOW]  = day_carry;
  assign fld_step[CI_DATE] = day_carry;
  assign fld_step[CI_MON]  = fld_wrap[CI_DATE];
  assign fld_step[CI_YEAR] = fld_wrap[CI_MON];

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_field
    if (gi == CI_DATE) begin : g_top_dyn
      assign fld_top[gi] = month_last_date(fld_val[CI_MON], fld_val[CI_YEAR]);
    end else begin : g_top_fix
      assign fld_top[gi] = ctr_top(gi);
    end

    rtcal_bcd_field #(
      .LOW_VAL   (ctr_low(gi)),
      .KEEP_MASK (ctr_keep(gi))
    ) u_fld (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (fld_step[gi]),
      .load_i     (wr_en && (wr_sel == ctr_sel(gi))),
      .load_val_i (wr_data),
      .top_i      (fld_top[gi]),
      .val_o      (fld_val[gi]),
      .wrap_o     (fld_wrap[gi])
    );
  end

  rtcal_hour_field u_hour (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_i     (hour_step),
    .load_i     (wr_en && (wr_sel == SEL_HOUR)),
    .load_val_i (wr_data),
    .val_o      (hour_val),
    .day_o      (day_carry)
  );

  assign sec_o   = {halt_q, fld_val[CI_SEC][6:0]};
  assign min_o   = fld_val[CI_MIN];
  assign hour_o  = hour_val;
  assign dow_o   = fld_val[CI_DOW];
  assign date_o  = fld_val[CI_DATE];
  assign month_o = fld_val[CI_MON];
  assign year_o  = fld_val[CI_YEAR];
  assign tick_o  = tick;
endmodule

// File: rtl/rtcal_checker.sv
module rtcal_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       tb_en,
  input logic       wr_en,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       tick_o,
  input logic       dow_wrap,
  input logic       year_wrap
);
  assert_sec_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[3:0] <= 4'd9) && (sec_o[6:4] <= 3'd5));

  assert_min_bcd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (min_o[3:0] <= 4'd9) && (min_o[6:4] <= 3'd5));

  assert_dow_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dow_o >= 8'h01) && (dow_o <= 8'h07));

  assert_dow_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dow_wrap |=> (dow_o == 8'h01));

  assert_year_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    year_wrap |=> (year_o == 8'h00) && (month_o == 8'h01) && (date_o == 8'h01));

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_o[7] && !wr_en) |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o)
                             && $stable(dow_o) && $stable(date_o) && $stable(month_o)
                             && $stable(year_o) && !tick_o);

  assert_tick_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> (tb_en && !sec_o[7] && !wr_en));

  assert_tick_adv_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (sec_o[6:0] != $past(sec_o[6:0])));

  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_o && !wr_en) |=> $stable(sec_o) && $stable(min_o) && $stable(hour_o)
                            && $stable(dow_o) && $stable(date_o) && $stable(month_o)
                            && $stable(year_o));

  assert_unused_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !min_o[7] && !hour_o[7] && (dow_o[7:3] == 5'd0) && (date_o[7:6] == 2'd0)
    && (month_o[7:5] == 3'd0));
endmodule

bind rtcal_core rtcal_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tb_en     (tb_en),
  .wr_en     (wr_en),
  .sec_o     (sec_o),
  .min_o     (min_o),
  .hour_o    (hour_o),
  .dow_o     (dow_o),
  .date_o    (date_o),
  .month_o   (month_o),
  .year_o    (year_o),
  .tick_o    (tick_o),
  .dow_wrap  (fld_wrap[rtcal_pkg::CI_DOW]),
  .year_wrap (fld_wrap[rtcal_pkg::CI_YEAR])
);

// File: tb/rtcal_core_test.sv
module rtcal_core_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tb_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_sel = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       tick_o;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rtcal_core #(.DIV_COUNT(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .tick_o(tick_o)
  );

  function automatic logic [7:0] tobcd(int n);
    return 8'(((n / 10) * 16) + (n % 10));
  endfunction

  function automatic int days_in(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] h12_byte(int n);
    int hr;
    hr = (n % 12 == 0) ? 12 : n % 12;
    return 8'h40 | ((n >= 12) ? 8'h20 : 8'h00) | tobcd(hr);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // DIV enables in a row; counts ticks and records the enable index
  task automatic one_sec(output int ticks, output int last_idx);
    ticks = 0; last_idx = -1;
    for (int k = 0; k < DIV; k++) begin
      @(negedge clk); tb_en = 1'b1;
      #1;
      if (tick_o) begin ticks++; last_idx = k; end
    end
    @(negedge clk); tb_en = 1'b0;
  endtask

  task automatic step_sec(input string tag);
    int t, li;
    one_sec(t, li);
    chk({tag, " R7 tick count"}, 8'(t), 8'd1);
    chk({tag, " R7 tick position"}, 8'(li), 8'(DIV - 1));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int t, li, found, d, nx;
    int years [7] = '{0, 1, 2, 3, 4, 98, 99};
    logic [7:0] snap [7];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 sec", sec_o, 8'h80);
    chk("R10 min", min_o, 8'h00);
    chk("R10 hour", hour_o, 8'h00);
    chk("R10 dow", dow_o, 8'h01);
    chk("R10 date", date_o, 8'h01);
    chk("R10 month", month_o, 8'h01);
    chk("R10 year", year_o, 8'h00);
    chk("R10 tick", 8'(tick_o), 8'h00);

    // R6 halted from reset
    for (int r = 0; r < 3; r++) begin
      one_sec(t, li);
      chk("R6 no tick while halted", 8'(t), 8'd0);
    end
    chk("R6 sec frozen", sec_o, 8'h80);

    // R1 full hour sweep
    wr(3'd0, 8'h00);
    for (int s = 1; s <= 3600; s++) begin
      step_sec("R1 sweep");
      chk("R1 seconds", sec_o, tobcd(s % 60));
      chk("R1 minutes", min_o, tobcd((s / 60) % 60));
    end
    chk("R2 hour after 60 min", hour_o, 8'h01);

    // R9 seconds write restarts prescaler
    for (int k = 0; k < 2; k++) begin @(negedge clk); tb_en = 1'b1; end
    @(negedge clk); tb_en = 1'b0;
    wr(3'd0, 8'h10);
    found = 0;
    for (int k = 0; k < 2 * DIV; k++) begin
      @(negedge clk); tb_en = 1'b1;
      #1;
      if (tick_o) begin found = k + 1; break; end
    end
    @(negedge clk); tb_en = 1'b0;
    chk("R9 enables to first tick", 8'(found), 8'(DIV));
    chk("R9 sec after restart", sec_o, 8'h11);

    // R8 write cycle swallows the enable
    for (int k = 0; k < DIV - 1; k++) begin
      @(negedge clk); tb_en = 1'b1;
      #1;
      chk("R8 no early tick", 8'(tick_o), 8'h00);
    end
    @(negedge clk);
    tb_en = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h33;
    #1;
    chk("R8 no tick during write", 8'(tick_o), 8'h00);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    chk("R8 tick on next enable", 8'(tick_o), 8'h01);
    @(negedge clk); tb_en = 1'b0;
    chk("R8 minutes written", min_o, 8'h33);
    chk("R8 seconds advanced once", sec_o, 8'h12);

    // R8 select 7 writes nothing
    snap = '{sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o};
    wr(3'd7, 8'h55);
    chk("R8 sel7 sec", sec_o, snap[0]);
    chk("R8 sel7 min", min_o, snap[1]);
    chk("R8 sel7 hour", hour_o, snap[2]);
    chk("R8 sel7 dow", dow_o, snap[3]);
    chk("R8 sel7 date", date_o, snap[4]);
    chk("R8 sel7 month", month_o, snap[5]);
    chk("R8 sel7 year", year_o, snap[6]);

    // R11 unused bits cleared on write
    wr(3'd1, 8'hA5); chk("R11 minutes mask", min_o, 8'h25);
    wr(3'd2, 8'h92); chk("R11 hours mask", hour_o, 8'h12);
    wr(3'd3, 8'hF5); chk("R11 dow mask", dow_o, 8'h05);
    wr(3'd4, 8'hC9); chk("R11 date mask", date_o, 8'h09);
    wr(3'd5, 8'hE7); chk("R11 month mask", month_o, 8'h07);

    // R2 24-hour day
    wr(3'd6, 8'h05); wr(3'd5, 8'h03); wr(3'd4, 8'h10); wr(3'd3, 8'h02);
    wr(3'd2, 8'h00);
    for (int n = 0; n < 24; n++) begin
      wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      step_sec("R2 day");
      nx = (n + 1) % 24;
      chk("R2 hour 24", hour_o, tobcd(nx));
      chk("R1 min carry", min_o, 8'h00);
      chk("R2 date carry", date_o, (nx == 0) ? 8'h11 : 8'h10);
      chk("R4 dow carry", dow_o, (nx == 0) ? 8'h03 : 8'h02);
    end

    // R3 12-hour day starting at 12 AM
    wr(3'd4, 8'h10); wr(3'd3, 8'h02); wr(3'd2, 8'h52);
    for (int n = 0; n < 24; n++) begin
      wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      step_sec("R3 day");
      nx = (n + 1) % 24;
      chk("R3 hour 12", hour_o, h12_byte(nx));
      chk("R3 date carry", date_o, (nx == 0) ? 8'h11 : 8'h10);
    end

    // R5 month ends across leap and non-leap years; R4 dow wrap
    d = 7;
    wr(3'd3, 8'h07);
    foreach (years[yi]) begin
      for (int m = 1; m <= 12; m++) begin
        for (int off = 0; off < 2; off++) begin
          int y, dt;
          y = years[yi];
          dt = days_in(m, y) - off;
          wr(3'd6, tobcd(y)); wr(3'd5, tobcd(m)); wr(3'd4, tobcd(dt));
          wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
          step_sec("R5 midnight");
          d = (d % 7) + 1;
          chk("R4 dow", dow_o, tobcd(d));
          chk("R2 hour wrap", hour_o, 8'h00);
          if (off == 0) begin
            chk("R5 date to 01", date_o, 8'h01);
            chk("R5 month advance", month_o, tobcd((m % 12) + 1));
            chk("R5 year", year_o, tobcd((m == 12) ? (y + 1) % 100 : y));
          end else begin
            chk("R5 date inc", date_o, tobcd(dt + 1));
            chk("R5 month hold", month_o, tobcd(m));
          end
        end
      end
    end

    // R6 halt set by write
    wr(3'd0, 8'hB0);
    chk("R6 halt write", sec_o, 8'hB0);
    snap[1] = min_o;
    for (int r = 0; r < 2; r++) begin
      one_sec(t, li);
      chk("R6 no tick after halt", 8'(t), 8'd0);
    end
    chk("R6 sec held", sec_o, 8'hB0);
    chk("R6 min held", min_o, snap[1]);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule